// File: doc/BRIEF.md
# Prioritised nesting interrupt controller

This block collects a set of level-sensitive interrupt request lines and presents at most one of them to a single processor. Each line carries a software-written enable bit and a priority level. A larger level means more urgency. Among the lines that are both raised and enabled, the block picks the most urgent one. It raises its interrupt output only when that level is strictly above the level the processor is running at.

When the processor accepts the request, the block hands back the winning line's index as the vector. On that same clock edge it lifts the running level to the accepted level and saves the level it replaced on an internal last-in-first-out store. A later end-of-service pulse takes the saved level back. Interrupts can therefore nest to any depth the store allows, and each return restores the level that was interrupted.

Top module: `nic_top`

## Requirements
- R1: After reset, int_req is 0, oper_prio is 0 and stk_ovf is 0. Every enable is 0 and every priority is 0, so no raised line can produce a request.
- R2: A configuration write with cfg_sel = 0 stores cfg_data[0] as the enable of line cfg_idx. A line whose enable is 0 never influences int_req or int_vec.
- R3: A configuration write with cfg_sel = 1 stores cfg_data as the priority of line cfg_idx. Among raised, enabled lines, the one with the numerically largest priority is selected.
- R4: When several eligible lines share the top priority, the lowest-numbered line wins. int_vec equals the winning line's index whenever int_req is 1.
- R5: int_req is 1 only when the selected priority is strictly greater than oper_prio. An equal or lower level, or no eligible line, gives int_req = 0. A priority-0 line therefore never interrupts.
- R6: int_req and int_vec are registered. A change on irq_in, or a configuration write, presented before clock edge k shows at int_req after edge k+1 and not after edge k.
- R7: On an edge where int_ack = 1 and int_req = 1, oper_prio becomes the level of the presented request. From the next cycle, int_req is judged against that new level. int_ack while int_req = 0 has no effect.
- R8: Each accepted request pushes the previous oper_prio onto a store of STACK_DEPTH entries. A more urgent request can therefore interrupt one already in service.
- R9: An eos pulse with a non-empty store sets oper_prio to the most recently saved level and removes it. An eos pulse with an empty store leaves oper_prio unchanged.
- R10: An acceptance while the store holds STACK_DEPTH entries drops the push, still raises oper_prio, and sets stk_ovf. stk_ovf stays 1 until reset.
- R11: When int_ack (with int_req = 1) and eos arrive on the same edge, the acceptance is performed and the eos is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | N_LINES | Level-sensitive request lines |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Line addressed by the write |
| cfg_sel | input | 1 | 0 writes the enable, 1 writes the priority |
| cfg_data | input | PRIO_W | Write data (bit 0 for an enable) |
| int_req | output | 1 | Interrupt request to the processor |
| int_vec | output | IDX_W | Index of the presented line |
| int_ack | input | 1 | Processor accepts the presented request |
| eos | input | 1 | End of the current service routine |
| oper_prio | output | PRIO_W | Current operating priority |
| stk_ovf | output | 1 | Sticky flag: a push was dropped on a full store |

## Verification
Three sweeps each apply all 256 request patterns on eight lines, and each one isolates a different part of the selection. With distinct priorities the sweep checks ordering by level and that a priority-0 line is ignored. With levels shared in pairs it checks tie-breaking by line index. With a sparse enable mask and reversed priorities it checks that disabled lines are filtered out before ranking. A nesting sequence then climbs one level per acceptance until the store is full and overflows. It checks the equal-level block, restores the saved levels in reverse order on eos, and covers an eos on an empty store and an acceptance coinciding with eos.

// File: rtl/nic_pkg.sv
package nic_pkg;

  // Meaning of the configuration select input.
  typedef enum logic {
    CFG_ENABLE = 1'b0,
    CFG_LEVEL  = 1'b1
  } cfg_kind_e;

  // Index width for a count of items, never below one bit.
  function automatic int unsigned idx_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/nic_cfg_regs.sv
module nic_cfg_regs import nic_pkg::*; #(
  parameter int N_LINES = 8,
  parameter int PRIO_W  = 3,
  parameter int IDX_W   = 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             we,
  input  logic [IDX_W-1:0]                 idx,
  input  logic                             sel,
  input  logic [PRIO_W-1:0]                data,
  output logic [N_LINES-1:0]               en_o,
  output logic [N_LINES-1:0][PRIO_W-1:0]   lvl_o
);

  cfg_kind_e kind;
  assign kind = cfg_kind_e'(sel);

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    logic hit;
    assign hit = we && (idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_o[g]  <= 1'b0;
        lvl_o[g] <= '0;
      end else if (hit) begin
        if (kind == CFG_ENABLE) en_o[g]  <= data[0];
        else                    lvl_o[g] <= data;
      end
    end
  end

endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter #(
  parameter int N_LINES = 8,
  parameter int PRIO_W  = 3,
  parameter int IDX_W   = 3
) (
  input  logic [N_LINES-1:0]             req,
  input  logic [N_LINES-1:0]             en,
  input  logic [N_LINES-1:0][PRIO_W-1:0] lvl,
  output logic                           found,
  output logic [IDX_W-1:0]               win_idx,
  output logic [PRIO_W-1:0]              win_lvl
);

  // A candidate displaces the current best only when strictly higher:
  // scanning upward, the lowest index keeps a tie.
  function automatic logic displaces(input logic have, input logic [PRIO_W-1:0] cand,
                                     input logic [PRIO_W-1:0] best);
    return !have || (cand > best);
  endfunction

  logic [N_LINES-1:0] elig;
  assign elig = req & en;

  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    win_lvl = '0;
    for (int i = 0; i < N_LINES; i++) begin
      if (elig[i] && displaces(found, lvl[i], win_lvl)) begin
        found   = 1'b1;
        win_idx = IDX_W'(i);
        win_lvl = lvl[i];
      end
    end
  end

endmodule

// File: rtl/nic_level_stack.sv
module nic_level_stack #(
  parameter int DEPTH  = 8,
  parameter int PRIO_W = 3,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [PRIO_W-1:0] push_lvl,
  output logic [PRIO_W-1:0] top_lvl,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              empty
);

  logic [CNT_W-1:0]             cnt_q;
  logic [DEPTH-1:0][PRIO_W-1:0] slot_q;
  logic                         do_push;
  logic                         do_pop;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !push && !empty;
  assign count   = cnt_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              slot_q[g] <= '0;
      else if (do_push && cnt_q == CNT_W'(g))  slot_q[g] <= push_lvl;
    end
  end

  always_comb begin
    top_lvl = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (cnt_q == CNT_W'(i + 1)) top_lvl = slot_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (do_push) cnt_q <= cnt_q + CNT_W'(1);
    else if (do_pop)  cnt_q <= cnt_q - CNT_W'(1);
  end

endmodule

// File: rtl/nic_top.sv
module nic_top import nic_pkg::*; #(
  parameter  int N_LINES     = 8,
  parameter  int PRIO_W      = 3,
  parameter  int STACK_DEPTH = 8,
  localparam int IDX_W       = idx_bits(N_LINES),
  localparam int CNT_W       = $clog2(STACK_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_in,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic               cfg_sel,
  input  logic [PRIO_W-1:0]  cfg_data,
  output logic               int_req,
  output logic [IDX_W-1:0]   int_vec,
  input  logic               int_ack,
  input  logic               eos,
  output logic [PRIO_W-1:0]  oper_prio,
  output logic               stk_ovf
);

  // Named internal events (also observed by the checker).
  logic [N_LINES-1:0]             irq_q;
  logic [N_LINES-1:0]             en;
  logic [N_LINES-1:0][PRIO_W-1:0] lvl;
  logic                           sel_found;
  logic [IDX_W-1:0]               sel_idx;
  logic [PRIO_W-1:0]              sel_lvl;
  logic                           accept;
  logic                           retire;
  logic [PRIO_W-1:0]              oper_q;
  logic [PRIO_W-1:0]              oper_next;
  logic                           req_q;
  logic                           req_next;
  logic [IDX_W-1:0]               vec_q;
  logic [PRIO_W-1:0]              req_lvl;
  logic                           ovf_q;
  logic [PRIO_W-1:0]              stk_top;
  logic [CNT_W-1:0]               stk_cnt;
  logic                           stk_full;
  logic                           stk_empty;

  // Next operating level: acceptance has precedence over return.
  function automatic logic [PRIO_W-1:0] level_after(
      input logic acc, input logic ret, input logic [PRIO_W-1:0] taken,
      input logic [PRIO_W-1:0] saved, input logic [PRIO_W-1:0] cur);
    if (acc)      return taken;
    else if (ret) return saved;
    else          return cur;
  endfunction

  function automatic logic outranks(input logic have, input logic [PRIO_W-1:0] cand,
                                    input logic [PRIO_W-1:0] running);
    return have && (cand > running);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_in;
  end

  nic_cfg_regs #(.N_LINES(N_LINES), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .idx   (cfg_idx),
    .sel   (cfg_sel),
    .data  (cfg_data),
    .en_o  (en),
    .lvl_o (lvl)
  );

  nic_arbiter #(.N_LINES(N_LINES), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_arb (
    .req     (irq_q),
    .en      (en),
    .lvl     (lvl),
    .found   (sel_found),
    .win_idx (sel_idx),
    .win_lvl (sel_lvl)
  );

  assign accept    = int_ack && req_q;
  assign retire    = eos && !accept && !stk_empty;
  assign oper_next = level_after(accept, retire, req_lvl, stk_top, oper_q);
  assign req_next  = outranks(sel_found, sel_lvl, oper_next);

  nic_level_stack #(.DEPTH(STACK_DEPTH), .PRIO_W(PRIO_W), .CNT_W(CNT_W)) u_stk (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (accept),
    .pop      (retire),
    .push_lvl (oper_q),
    .top_lvl  (stk_top),
    .count    (stk_cnt),
    .full     (stk_full),
    .empty    (stk_empty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oper_q  <= '0;
      req_q   <= 1'b0;
      vec_q   <= '0;
      req_lvl <= '0;
      ovf_q   <= 1'b0;
    end else begin
      oper_q  <= oper_next;
      req_q   <= req_next;
      vec_q   <= req_next ? sel_idx : '0;
      req_lvl <= req_next ? sel_lvl : '0;
      ovf_q   <= ovf_q || (accept && stk_full);
    end
  end

  assign int_req   = req_q;
  assign int_vec   = vec_q;
  assign oper_prio = oper_q;
  assign stk_ovf   = ovf_q;

endmodule

// File: rtl/nic_checker.sv
module nic_checker #(
  parameter int PRIO_W = 3,
  parameter int CNT_W  = 4,
  parameter int DEPTH  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              int_req,
  input logic              int_ack,
  input logic              eos,
  input logic [PRIO_W-1:0] oper_prio,
  input logic              stk_ovf,
  input logic [PRIO_W-1:0] req_lvl,
  input logic [CNT_W-1:0]  stk_cnt,
  input logic              stk_full,
  input logic              stk_empty
);

  logic took;
  assign took = int_ack && int_req;

  p_req_above_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> (req_lvl > oper_prio));

  p_req_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> (req_lvl != '0));

  p_accept_raises_r7: assert property (@(posedge clk) disable iff (!rst_n)
    took |=> (oper_prio == $past(req_lvl)));

  p_idle_ack_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && !int_req && !eos) |=> $stable(oper_prio));

  p_push_grows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (took && !stk_full) |=> (stk_cnt == $past(stk_cnt) + CNT_W'(1)));

  p_depth_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stk_cnt <= CNT_W'(DEPTH));

  p_pop_shrinks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (eos && !took && !stk_empty) |=> (stk_cnt == $past(stk_cnt) - CNT_W'(1)));

  p_empty_eos_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (eos && !took && stk_empty) |=> $stable(oper_prio));

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (took && stk_full) |=> (stk_ovf && stk_cnt == $past(stk_cnt)));

  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stk_ovf |=> stk_ovf);

  p_ack_beats_eos_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (took && eos && !stk_full) |=> (stk_cnt != '0));

endmodule

bind nic_top nic_checker #(.PRIO_W(PRIO_W), .CNT_W(CNT_W), .DEPTH(STACK_DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .int_req   (int_req),
  .int_ack   (int_ack),
  .eos       (eos),
  .oper_prio (oper_prio),
  .stk_ovf   (stk_ovf),
  .req_lvl   (req_lvl),
  .stk_cnt   (stk_cnt),
  .stk_full  (stk_full),
  .stk_empty (stk_empty)
);

// File: tb/nic_top_tb.sv
module nic_top_tb;

  localparam int N   = 8;
  localparam int PW  = 3;
  localparam int DEP = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] irq_in = '0;
  logic         cfg_we = 1'b0;
  logic [2:0]   cfg_idx = '0;
  logic         cfg_sel = 1'b0;
  logic [PW-1:0] cfg_data = '0;
  logic         int_req;
  logic [2:0]   int_vec;
  logic         int_ack = 1'b0;
  logic         eos = 1'b0;
  logic [PW-1:0] oper_prio;
  logic         stk_ovf;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;
  int m_en [N];
  int m_lvl[N];

  always #5 clk = ~clk;

  nic_top #(.N_LINES(N), .PRIO_W(PW), .STACK_DEPTH(DEP)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_sel(cfg_sel), .cfg_data(cfg_data), .int_req(int_req), .int_vec(int_vec),
    .int_ack(int_ack), .eos(eos), .oper_prio(oper_prio), .stk_ovf(stk_ovf)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int idx, input bit sel, input int data);
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_sel = sel; cfg_data = PW'(data);
    tick();
    cfg_we = 1'b0;
    if (sel) m_lvl[idx] = data; else m_en[idx] = data & 1;
  endtask

  // Expected pick: walk levels from the top down, lines from 0 up.
  task automatic expect_pick(input int pat, input int oper, output bit v, output int idx);
    v = 0; idx = 0;
    for (int l = 7; l > oper && !v; l--)
      for (int i = 0; i < N && !v; i++)
        if (((pat >> i) & 1) == 1 && m_en[i] == 1 && m_lvl[i] == l) begin
          v = 1; idx = i;
        end
  endtask

  task automatic sweep(input string tag);
    bit v; int idx;
    for (int p = 0; p < 256; p++) begin
      irq_in = N'(p);
      tick(); tick();
      expect_pick(p, 0, v, idx);
      chk({tag, " req"}, int'(int_req), int'(v));
      if (v) chk({tag, " vec"}, int'(int_vec), idx);
    end
    irq_in = '0; tick(); tick();
  endtask

  task automatic accept_now();
    int_ack = 1'b1; tick(); int_ack = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_en[i] = 0; m_lvl[i] = 0; end
    #23 rst_n = 1'b1;
    tick();
    // R1: reset state, and raised lines with cleared enables give nothing
    chk("R1 int_req", int'(int_req), 0);
    chk("R1 oper_prio", int'(oper_prio), 0);
    chk("R1 stk_ovf", int'(stk_ovf), 0);
    irq_in = '1; tick(); tick();
    chk("R1 no request with reset config", int'(int_req), 0);
    // R2 enable writes; priorities still zero -> R5 level zero never interrupts
    for (int i = 0; i < N; i++) wr(i, 1'b0, 1);
    tick(); tick();
    chk("R5 priority zero blocked", int'(int_req), 0);
    irq_in = '0;

    // R3: distinct levels, line i has level i
    for (int i = 0; i < N; i++) wr(i, 1'b1, i);
    sweep("R3 distinct");
    // R4: shared levels in pairs
    for (int i = 0; i < N; i++) wr(i, 1'b1, (i >> 1) + 1);
    sweep("R4 ties");
    // R2: sparse enables, reversed levels
    for (int i = 0; i < N; i++) wr(i, 1'b1, 7 - i);
    for (int i = 0; i < N; i++) wr(i, 1'b0, (8'b1011_0100 >> i) & 1);
    sweep("R2 masked");

    // R6: latency, line 2 enabled at level 5
    irq_in = 8'b0000_0100;
    tick();
    chk("R6 not after first edge", int'(int_req), 0);
    tick();
    chk("R6 after second edge", int'(int_req), 1);
    irq_in = '0;
    wr(2, 1'b0, 0);
    irq_in = 8'b0000_0100;
    tick(); tick();
    chk("R2 disabled by write", int'(int_req), 0);
    irq_in = '0;
    wr(2, 1'b0, 1);
    tick();
    chk("R6 config write not after first edge", int'(int_req), 0);
    irq_in = 8'b0000_0100;
    tick(); tick();
    chk("R6 config write after second edge", int'(int_req), 1);
    irq_in = '0; tick(); tick();

    // Nesting: all enabled, line i at level i
    for (int i = 0; i < N; i++) begin wr(i, 1'b0, 1); wr(i, 1'b1, i); end
    for (int l = 1; l <= DEP; l++) begin
      irq_in = irq_in | N'(1 << l);
      tick(); tick();
      chk("R8 nested request raised", int'(int_req), 1);
      chk("R7 vector", int'(int_vec), l);
      accept_now();
      chk("R7 level raised", int'(oper_prio), l);
      chk("R5 equal level blocked", int'(int_req), 0);
    end
    chk("R10 no overflow while room", int'(stk_ovf), 0);
    irq_in = irq_in | N'(1 << 5);
    tick(); tick();
    chk("R7 vector before overflow", int'(int_vec), 5);
    accept_now();
    chk("R10 level raised on full", int'(oper_prio), 5);
    chk("R10 overflow set", int'(stk_ovf), 1);
    // R7: acknowledge without request
    int_ack = 1'b1; tick(); int_ack = 1'b0;
    chk("R7 idle ack ignored", int'(oper_prio), 5);
    irq_in = '0; tick(); tick();
    // R9: pops restore 3,2,1,0 (the dropped push of 4 is lost)
    for (int k = DEP - 1; k >= 0; k--) begin
      eos = 1'b1; tick(); eos = 1'b0;
      chk("R9 level restored", int'(oper_prio), k);
    end
    eos = 1'b1; tick(); eos = 1'b0;
    chk("R9 empty eos ignored", int'(oper_prio), 0);
    chk("R10 overflow sticky", int'(stk_ovf), 1);

    // R11: ack and eos together
    irq_in = 8'b0100_0000;
    tick(); tick();
    chk("R11 request up", int'(int_req), 1);
    int_ack = 1'b1; eos = 1'b1; tick(); int_ack = 1'b0; eos = 1'b0;
    chk("R11 accept wins", int'(oper_prio), 6);
    irq_in = '0;
    eos = 1'b1; tick(); eos = 1'b0;
    chk("R11 pushed level restored", int'(oper_prio), 0);
    tick(); tick();
    chk("R11 no request afterwards", int'(int_req), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule